// File: doc/BRIEF.md
# Physical Register Free List

This block tracks which physical registers of a renaming out-of-order core are unallocated. All physical registers share one index space. Integer registers use indices `0 .. NUM_INT_PHYS-1`. Floating-point registers follow at `NUM_INT_PHYS .. NUM_INT_PHYS+NUM_FP_PHYS-1`. The block keeps one circular FIFO pool per register class. A single free port returns an index to the pool that owns it. Each class has its own allocation port, which pops the oldest free register.

The integer zero register at index `ZERO_IDX` is hard-wired, so it never re-enters a pool. The build-time parameter `SKIP_FP_ZERO` selects whether the floating-point zero register (index `ZERO_IDX + NUM_INT_PHYS`) is also held back or is recycled like any other floating-point register.

At reset each architectural register `r` of a class is taken to be mapped to the physical register of the same offset within that class. Every remaining register is preloaded into its pool. `ZERO_IDX` must be below `NUM_INT_ARCH`.

An allocation answers within the same cycle, and the pop takes effect at the clock edge. With the defaults (16 integer and 12 floating-point physical registers, 8 architectural registers of each class, zero index 0), the index width is 5 bits. The valid indices are 0..27, and indices 28..31 are out of range.

Top module: `phys_free_list`

## Requirements
- R1: After reset the integer pool holds `NUM_INT_ARCH .. NUM_INT_PHYS-1` in ascending pop order, and the floating-point pool holds `NUM_INT_PHYS+NUM_FP_ARCH .. TOTAL-1` in ascending pop order. With the defaults this is 8 and 4 entries. `int_count`/`fp_count` give these numbers.
- R2: A freed index below `NUM_INT_PHYS`, other than the integer zero index, is appended to the tail of the integer pool. Pops return entries in the order they were appended.
- R3: A freed index `i` with `NUM_INT_PHYS <= i < TOTAL` is appended to the tail of the floating-point pool, unless R5 excludes it.
- R4: Freeing `ZERO_IDX` changes neither pool.
- R5: With `SKIP_FP_ZERO=1`, freeing `ZERO_IDX+NUM_INT_PHYS` changes neither pool. With `SKIP_FP_ZERO=0`, that index is appended to the floating-point pool like any other floating-point index.
- R6: Freeing an index `>= TOTAL` changes neither pool.
- R7: A request on a non-empty pool gives, in the same cycle, `*_alloc_valid=1`, `*_alloc_err=0` and `*_alloc_idx` equal to the pool head. The head leaves the pool at the next rising edge.
- R8: A request on an empty pool gives `*_alloc_err=1` and `*_alloc_valid=0` in that cycle. Nothing is popped.
- R9: `*_empty` is 1 exactly when the pool's count is 0.
- R10: A free and an allocation in the same cycle both take effect, and the count changes by the net amount. An allocation from an empty pool cannot take the register being freed in that same cycle.
- R11: A pool's capacity is its class's physical register count, and `*_full` is 1 exactly at capacity. A free into a full pool is dropped, unless the same pool pops in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, reloads both pools |
| free_valid | input | 1 | A register is being returned this cycle |
| free_idx | input | IDX_W | Unified physical index being returned |
| int_alloc_req | input | 1 | Request one integer register |
| int_alloc_valid | output | 1 | Integer allocation granted this cycle |
| int_alloc_idx | output | IDX_W | Granted integer index (0 when not granted) |
| int_alloc_err | output | 1 | Integer request made while the pool is empty |
| fp_alloc_req | input | 1 | Request one floating-point register |
| fp_alloc_valid | output | 1 | Floating-point allocation granted this cycle |
| fp_alloc_idx | output | IDX_W | Granted floating-point index (0 when not granted) |
| fp_alloc_err | output | 1 | Floating-point request made while the pool is empty |
| int_empty | output | 1 | Integer pool has no entries |
| int_full | output | 1 | Integer pool at capacity |
| int_count | output | ICNT_W | Integer pool occupancy |
| fp_empty | output | 1 | Floating-point pool has no entries |
| fp_full | output | 1 | Floating-point pool at capacity |
| fp_count | output | FCNT_W | Floating-point pool occupancy |

## Verification
The assertions check on every cycle that any granted index belongs to the right class and is never a held-back zero register. They also check that requests on an empty pool error out, that the empty flags track the counts, and that frees of the zero index or of out-of-range indices leave the counts unchanged. The assertions cannot show the FIFO ordering, the reset preload contents, the exact routing of every index, or the difference between the two `SKIP_FP_ZERO` builds. The bench shows these with a sweep that frees every encodable index. It runs two instances, one per setting of `SKIP_FP_ZERO`. The bench also drains both pools against an arithmetic model, overfills both pools and mixes same-cycle frees with allocations.

// File: rtl/prf_pkg.sv
package prf_pkg;

    // Destination of a returned physical register.
    typedef enum logic [1:0] {
        DEST_NONE = 2'd0,
        DEST_INT  = 2'd1,
        DEST_FP   = 2'd2
    } free_dest_e;

    // Decide which pool, if any, receives a freed unified index.
    function automatic free_dest_e route_free(
        input int idx,
        input int n_int,
        input int n_total,
        input int zero_idx,
        input bit skip_fp_zero
    );
        free_dest_e d;
        if (idx < n_int) begin
            d = (idx == zero_idx) ? DEST_NONE : DEST_INT;
        end else if (idx < n_total) begin
            d = (skip_fp_zero && (idx == zero_idx + n_int)) ? DEST_NONE : DEST_FP;
        end else begin
            d = DEST_NONE;
        end
        return d;
    endfunction

    // Pointer step with wrap at an arbitrary depth.
    function automatic int ring_step(input int ptr, input int depth);
        return (ptr == depth - 1) ? 0 : ptr + 1;
    endfunction

endpackage

// File: rtl/prf_free_route.sv
module prf_free_route
    import prf_pkg::*;
#(
    parameter int NUM_INT_PHYS = 16,
    parameter int NUM_FP_PHYS  = 12,
    parameter int ZERO_IDX     = 0,
    parameter bit SKIP_FP_ZERO = 1'b1,
    localparam int TOTAL       = NUM_INT_PHYS + NUM_FP_PHYS,
    localparam int IDX_W       = $clog2(TOTAL + 1)
) (
    input  logic             free_valid,
    input  logic [IDX_W-1:0] free_idx,
    output logic             push_int,
    output logic             push_fp
);

    free_dest_e dest;

    always_comb begin
        dest     = route_free(int'(free_idx), NUM_INT_PHYS, TOTAL, ZERO_IDX, SKIP_FP_ZERO);
        push_int = free_valid && (dest == DEST_INT);
        push_fp  = free_valid && (dest == DEST_FP);
    end

endmodule

// File: rtl/prf_pool_fifo.sv
module prf_pool_fifo
    import prf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int W         = 5,
    parameter int BASE      = 8,
    parameter int PRELOAD   = 8,
    localparam int PTR_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [W-1:0]     push_idx,
    input  logic             pop_req,
    output logic [W-1:0]     head_idx,
    output logic             pop_valid,
    output logic             pop_err,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] count
);

    logic [W-1:0]     slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             pop_ok;
    logic             push_ok;

    always_comb begin
        empty     = (cnt == '0);
        full      = (cnt == CNT_W'(DEPTH));
        pop_ok    = pop_req && !empty;
        push_ok   = push && (!full || pop_ok);
        pop_valid = pop_ok;
        pop_err   = pop_req && empty;
        head_idx  = pop_ok ? slots[rd_ptr] : '0;
        count     = cnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                slots[i] <= (i < PRELOAD) ? W'(BASE + i) : '0;
            end
            rd_ptr <= '0;
            wr_ptr <= PTR_W'(PRELOAD % DEPTH);
            cnt    <= CNT_W'(PRELOAD);
        end else begin
            if (push_ok) begin
                slots[wr_ptr] <= push_idx;
                wr_ptr        <= PTR_W'(ring_step(int'(wr_ptr), DEPTH));
            end
            if (pop_ok) begin
                rd_ptr <= PTR_W'(ring_step(int'(rd_ptr), DEPTH));
            end
            case ({push_ok, pop_ok})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/phys_free_list.sv
module phys_free_list
    import prf_pkg::*;
#(
    parameter int NUM_INT_PHYS = 16,
    parameter int NUM_FP_PHYS  = 12,
    parameter int NUM_INT_ARCH = 8,
    parameter int NUM_FP_ARCH  = 8,
    parameter int ZERO_IDX     = 0,
    parameter bit SKIP_FP_ZERO = 1'b1,
    localparam int TOTAL       = NUM_INT_PHYS + NUM_FP_PHYS,
    localparam int IDX_W       = $clog2(TOTAL + 1),
    localparam int ICNT_W      = $clog2(NUM_INT_PHYS + 1),
    localparam int FCNT_W      = $clog2(NUM_FP_PHYS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              free_valid,
    input  logic [IDX_W-1:0]  free_idx,
    input  logic              int_alloc_req,
    output logic              int_alloc_valid,
    output logic [IDX_W-1:0]  int_alloc_idx,
    output logic              int_alloc_err,
    input  logic              fp_alloc_req,
    output logic              fp_alloc_valid,
    output logic [IDX_W-1:0]  fp_alloc_idx,
    output logic              fp_alloc_err,
    output logic              int_empty,
    output logic              int_full,
    output logic [ICNT_W-1:0] int_count,
    output logic              fp_empty,
    output logic              fp_full,
    output logic [FCNT_W-1:0] fp_count
);

    localparam int INT_BASE    = NUM_INT_ARCH;
    localparam int INT_PRELOAD = NUM_INT_PHYS - NUM_INT_ARCH;
    localparam int FP_BASE     = NUM_INT_PHYS + NUM_FP_ARCH;
    localparam int FP_PRELOAD  = NUM_FP_PHYS - NUM_FP_ARCH;

    logic push_int;
    logic push_fp;

    prf_free_route #(
        .NUM_INT_PHYS (NUM_INT_PHYS),
        .NUM_FP_PHYS  (NUM_FP_PHYS),
        .ZERO_IDX     (ZERO_IDX),
        .SKIP_FP_ZERO (SKIP_FP_ZERO)
    ) u_route (
        .free_valid (free_valid),
        .free_idx   (free_idx),
        .push_int   (push_int),
        .push_fp    (push_fp)
    );

    prf_pool_fifo #(
        .DEPTH   (NUM_INT_PHYS),
        .W       (IDX_W),
        .BASE    (INT_BASE),
        .PRELOAD (INT_PRELOAD)
    ) u_int_pool (
        .clk       (clk),
        .rst       (rst),
        .push      (push_int),
        .push_idx  (free_idx),
        .pop_req   (int_alloc_req),
        .head_idx  (int_alloc_idx),
        .pop_valid (int_alloc_valid),
        .pop_err   (int_alloc_err),
        .empty     (int_empty),
        .full      (int_full),
        .count     (int_count)
    );

    prf_pool_fifo #(
        .DEPTH   (NUM_FP_PHYS),
        .W       (IDX_W),
        .BASE    (FP_BASE),
        .PRELOAD (FP_PRELOAD)
    ) u_fp_pool (
        .clk       (clk),
        .rst       (rst),
        .push      (push_fp),
        .push_idx  (free_idx),
        .pop_req   (fp_alloc_req),
        .head_idx  (fp_alloc_idx),
        .pop_valid (fp_alloc_valid),
        .pop_err   (fp_alloc_err),
        .empty     (fp_empty),
        .full      (fp_full),
        .count     (fp_count)
    );

endmodule

// File: rtl/phys_free_list_chk.sv
module phys_free_list_chk #(
    parameter int NUM_INT_PHYS = 16,
    parameter int NUM_FP_PHYS  = 12,
    parameter int ZERO_IDX     = 0,
    parameter bit SKIP_FP_ZERO = 1'b1,
    localparam int TOTAL       = NUM_INT_PHYS + NUM_FP_PHYS,
    localparam int IDX_W       = $clog2(TOTAL + 1),
    localparam int ICNT_W      = $clog2(NUM_INT_PHYS + 1),
    localparam int FCNT_W      = $clog2(NUM_FP_PHYS + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              free_valid,
    input logic [IDX_W-1:0]  free_idx,
    input logic              int_alloc_req,
    input logic              int_alloc_valid,
    input logic [IDX_W-1:0]  int_alloc_idx,
    input logic              int_alloc_err,
    input logic              fp_alloc_req,
    input logic              fp_alloc_valid,
    input logic [IDX_W-1:0]  fp_alloc_idx,
    input logic              fp_alloc_err,
    input logic              int_empty,
    input logic [ICNT_W-1:0] int_count,
    input logic              fp_empty,
    input logic [FCNT_W-1:0] fp_count
);

    localparam logic [IDX_W-1:0] N_INT   = IDX_W'(NUM_INT_PHYS);
    localparam logic [IDX_W-1:0] N_TOT   = IDX_W'(TOTAL);
    localparam logic [IDX_W-1:0] Z_INT   = IDX_W'(ZERO_IDX);
    localparam logic [IDX_W-1:0] Z_FP    = IDX_W'(ZERO_IDX + NUM_INT_PHYS);

    // R7: granted integer index is an integer register and never the zero register
    a_r7_int_class: assert property (@(posedge clk) disable iff (rst)
        int_alloc_valid |-> (int_alloc_idx < N_INT && int_alloc_idx != Z_INT));

    // R7 / R5: granted floating-point index is in the upper range and not a held-back zero
    a_r7_fp_class: assert property (@(posedge clk) disable iff (rst)
        fp_alloc_valid |-> (fp_alloc_idx >= N_INT && fp_alloc_idx < N_TOT &&
                            (!SKIP_FP_ZERO || fp_alloc_idx != Z_FP)));

    // R8: requests on an empty pool report an error and grant nothing
    a_r8_int_empty_req: assert property (@(posedge clk) disable iff (rst)
        (int_alloc_req && int_empty) |-> (int_alloc_err && !int_alloc_valid));

    a_r8_fp_empty_req: assert property (@(posedge clk) disable iff (rst)
        (fp_alloc_req && fp_empty) |-> (fp_alloc_err && !fp_alloc_valid));

    // R9: empty flags track occupancy
    a_r9_int_empty_flag: assert property (@(posedge clk) disable iff (rst)
        int_empty == (int_count == '0));

    a_r9_fp_empty_flag: assert property (@(posedge clk) disable iff (rst)
        fp_empty == (fp_count == '0));

    // R4: freeing the integer zero register never grows the integer pool
    a_r4_zero_kept_out: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && free_valid && free_idx == Z_INT && !int_alloc_req) |-> $stable(int_count));

    // R6: out-of-range frees leave both pools unchanged
    a_r6_out_of_range: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && free_valid && free_idx >= N_TOT && !int_alloc_req && !fp_alloc_req)
        |-> ($stable(int_count) && $stable(fp_count)));

    // R10: a grant with a simultaneous integer free leaves the integer count unchanged
    a_r10_int_net: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && int_alloc_valid && free_valid && free_idx < N_INT && free_idx != Z_INT)
        |-> $stable(int_count));

    // R7: a lone grant lowers the integer count by one
    a_r7_int_pop_count: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && int_alloc_valid && !free_valid) |-> (int_count == $past(int_count) - 1'b1));

endmodule

bind phys_free_list phys_free_list_chk #(
    .NUM_INT_PHYS (NUM_INT_PHYS),
    .NUM_FP_PHYS  (NUM_FP_PHYS),
    .ZERO_IDX     (ZERO_IDX),
    .SKIP_FP_ZERO (SKIP_FP_ZERO)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .free_valid      (free_valid),
    .free_idx        (free_idx),
    .int_alloc_req   (int_alloc_req),
    .int_alloc_valid (int_alloc_valid),
    .int_alloc_idx   (int_alloc_idx),
    .int_alloc_err   (int_alloc_err),
    .fp_alloc_req    (fp_alloc_req),
    .fp_alloc_valid  (fp_alloc_valid),
    .fp_alloc_idx    (fp_alloc_idx),
    .fp_alloc_err    (fp_alloc_err),
    .int_empty       (int_empty),
    .int_count       (int_count),
    .fp_empty        (fp_empty),
    .fp_count        (fp_count)
);

// File: tb/phys_free_list_test.sv
module phys_free_list_test;

    localparam int NI    = 16;
    localparam int NF    = 12;
    localparam int NAI   = 8;
    localparam int NAF   = 8;
    localparam int TOT   = NI + NF;
    localparam int IW    = $clog2(TOT + 1);
    localparam int ICW   = $clog2(NI + 1);
    localparam int FCW   = $clog2(NF + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic          free_valid = 1'b0;
    logic [IW-1:0] free_idx = '0;
    logic          int_req = 1'b0;
    logic          fp_req = 1'b0;

    logic          a_iv, a_ie, a_fv, a_fe, a_iem, a_ifl, a_fem, a_ffl;
    logic [IW-1:0] a_ii, a_fi;
    logic [ICW-1:0] a_ic;
    logic [FCW-1:0] a_fc;
    logic          b_iv, b_ie, b_fv, b_fe, b_iem, b_ifl, b_fem, b_ffl;
    logic [IW-1:0] b_ii, b_fi;
    logic [ICW-1:0] b_ic;
    logic [FCW-1:0] b_fc;

    always #5 clk = ~clk;

    phys_free_list uut (
        .clk(clk), .rst(rst), .free_valid(free_valid), .free_idx(free_idx),
        .int_alloc_req(int_req), .int_alloc_valid(a_iv), .int_alloc_idx(a_ii), .int_alloc_err(a_ie),
        .fp_alloc_req(fp_req), .fp_alloc_valid(a_fv), .fp_alloc_idx(a_fi), .fp_alloc_err(a_fe),
        .int_empty(a_iem), .int_full(a_ifl), .int_count(a_ic),
        .fp_empty(a_fem), .fp_full(a_ffl), .fp_count(a_fc)
    );

    phys_free_list #(.SKIP_FP_ZERO(1'b0)) uut_fpz (
        .clk(clk), .rst(rst), .free_valid(free_valid), .free_idx(free_idx),
        .int_alloc_req(int_req), .int_alloc_valid(b_iv), .int_alloc_idx(b_ii), .int_alloc_err(b_ie),
        .fp_alloc_req(fp_req), .fp_alloc_valid(b_fv), .fp_alloc_idx(b_fi), .fp_alloc_err(b_fe),
        .int_empty(b_iem), .int_full(b_ifl), .int_count(b_ic),
        .fp_empty(b_fem), .fp_full(b_ffl), .fp_count(b_fc)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference pools: integer (shared by both builds), fp with skip, fp without skip
    int mi[$];
    int mf1[$];
    int mf0[$];

    task automatic check(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic check_side(input string tag, input bit req, ref int q[$], input int depth,
                              input logic v, input logic [IW-1:0] idx, input logic e,
                              input logic em, input logic fl, input int cnt);
        bit have;
        have = (q.size() > 0);
        check({tag, " grant (R7)"}, int'(v), int'(req && have));
        check({tag, " error (R8)"}, int'(e), int'(req && !have));
        if (req && have) check({tag, " head order (R2/R3)"}, int'(idx), q[0]);
        check({tag, " count (R10)"}, cnt, q.size());
        check({tag, " empty (R9)"}, int'(em), int'(q.size() == 0));
        check({tag, " full (R11)"}, int'(fl), int'(q.size() == depth));
    endtask

    task automatic upd(ref int q[$], input bit req, input bit push, input int v, input int depth);
        bit popped;
        popped = req && (q.size() > 0);
        if (popped) void'(q.pop_front());
        if (push && (q.size() < depth)) q.push_back(v);
    endtask

    task automatic step(input string scn, input bit fv, input int fi, input bit ir, input bit fr);
        bit to_int, to_fp1, to_fp0;
        @(negedge clk);
        free_valid = fv;
        free_idx   = IW'(fi);
        int_req    = ir;
        fp_req     = fr;
        #1;
        check_side({scn, " int"}, ir, mi, NI, a_iv, a_ii, a_ie, a_iem, a_ifl, int'(a_ic));
        check_side({scn, " fp skip"}, fr, mf1, NF, a_fv, a_fi, a_fe, a_fem, a_ffl, int'(a_fc));
        check_side({scn, " int b"}, ir, mi, NI, b_iv, b_ii, b_ie, b_iem, b_ifl, int'(b_ic));
        check_side({scn, " fp keep"}, fr, mf0, NF, b_fv, b_fi, b_fe, b_fem, b_ffl, int'(b_fc));
        // R4 R5 R6 routing computed from the index ranges
        to_int = fv && fi < NI && fi != 0;
        to_fp0 = fv && fi >= NI && fi < TOT;
        to_fp1 = to_fp0 && fi != NI;
        upd(mi, ir, to_int, fi, NI);
        upd(mf1, fr, to_fp1, fi, NF);
        upd(mf0, fr, to_fp0, fi, NF);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = NAI; i < NI; i++) mi.push_back(i);
        for (int i = NI + NAF; i < TOT; i++) begin
            mf1.push_back(i);
            mf0.push_back(i);
        end
        step("R1 reset state", 1'b0, 0, 1'b0, 1'b0);
        for (int i = 0; i < NI - NAI; i++) step("R1 R7 drain int", 1'b0, 0, 1'b1, 1'b0);
        step("R8 R9 int empty request", 1'b0, 0, 1'b1, 1'b0);
        for (int i = 0; i < NF - NAF; i++) step("R1 R7 drain fp", 1'b0, 0, 1'b0, 1'b1);
        step("R8 R9 fp empty request", 1'b0, 0, 1'b0, 1'b1);
        for (int i = 0; i < (1 << IW); i++) step("R2 R3 R4 R5 R6 free sweep", 1'b1, i, 1'b0, 1'b0);
        step("R11 overfill a", 1'b1, 20, 1'b0, 1'b0);
        step("R11 overfill b", 1'b1, 21, 1'b0, 1'b0);
        step("R11 overfill int a", 1'b1, 5, 1'b0, 1'b0);
        step("R11 overfill int b", 1'b1, 6, 1'b0, 1'b0);
        step("R10 R11 full pop and free", 1'b1, 7, 1'b1, 1'b0);
        for (int k = 0; k < 6; k++) begin
            step("R10 same-cycle int", 1'b1, 4 + k, 1'b1, 1'b1);
            step("R10 same-cycle fp", 1'b1, 18 + k, 1'b1, 1'b1);
        end
        for (int k = 0; k < 20; k++) step("R2 R3 drain order", 1'b0, 0, 1'b1, 1'b1);
        step("R8 R10 empty request with free", 1'b1, 9, 1'b1, 1'b0);
        step("R8 R10 fp empty request with free", 1'b1, 16, 1'b0, 1'b1);
        step("R5 R7 after late free", 1'b0, 0, 1'b1, 1'b1);
        step("R9 idle", 1'b0, 0, 1'b0, 1'b0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run completed)");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule